// File: doc/BRIEF.md
# Paired-Beat Floating-Point Reservation Station

This block queues floating-point operations in front of three execution pipes: add/subtract, multiply, and detect/move. The dispatcher sends each operation as two beats in a row. The first beat is a fill beat. It carries the low halves of both operands, plus a source code and a tag for each operand. The second beat carries the high halves, the opcode and a destination tag. The two beats are combined into one station entry, and only a combined entry can be issued.

Each operand is in one of three states. An operand from the register file or from a non-FPU unit first spends one cycle in a conversion stage, modelled here as a registered pass-through. An operand already in internal format (a value forwarded from an FPU pipe) is ready at once. An operand still waiting on a result takes that result from any pipe's return port when the tags match, and is then treated as already converted. An add result flagged with cancellation is held one extra cycle before it is forwarded, to account for normalization.

The station holds a parameterised number of entries (four by default). Each cycle it issues one entry: the oldest entry that is ready and whose target pipe is accepting. A beat order that breaks the pairing raises an error pulse.

Top module: `fprs_top`

## Requirements
- R1: An issued operation carries operand A as {second-beat A half, fill-beat A half}, operand B built the same way, and the opcode and destination tag from the second beat.
- R2: The target pipe comes from opcode bits [3:2]: 00 selects add (iss_valid bit 0), 01 selects multiply (bit 1), and 10 or 11 select detect/move (bit 2). At most one iss_valid bit is high, and only toward a pipe whose pipe_ready is high.
- R3: If both operands have source code 01 (internal format), the entry is offered for issue in the cycle right after the clock edge that accepts its second beat.
- R4: If either operand has source code 00 (external, needs conversion), the issue comes one cycle later than in R3.
- R5: An operand with source code 10 (waiting) takes the data of a result port whose tag matches. The entry can then issue in the cycle after that result's edge, with no conversion cycle added.
- R6: An add result presented with add_res_cancel high reaches waiting operands one cycle later than an add result presented without it.
- R7: A second beat that has no fill beat before it, or a fill beat that follows another fill beat, makes proto_err high for the one cycle after the beat's accepting edge. A stray second beat creates no entry. With two fills in a row, the earlier fill is discarded and the later one pairs with the next second beat.
- R8: With every entry reserved, disp_ready is low for a fill beat. disp_ready is always high for a second beat.
- R9: Among the entries that can issue, the one whose fill beat came earliest issues first. An entry waiting on a stalled pipe does not block younger entries bound for other pipes.
- R10: During reset and in the first cycle after it, iss_valid is zero, proto_err is low and disp_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch beat present |
| disp_ready | output | 1 | Station accepts the beat |
| disp_fill | input | 1 | 1 = fill beat, 0 = second (opcode) beat |
| disp_a_half | input | 32 | A low half on fill beat, A high half on second beat |
| disp_b_half | input | 32 | B low half on fill beat, B high half on second beat |
| disp_a_src | input | 2 | Fill beat: A source (00 external, 01 internal, 10 waiting) |
| disp_b_src | input | 2 | Fill beat: B source, same code |
| disp_a_tag | input | 4 | Fill beat: tag A waits on |
| disp_b_tag | input | 4 | Fill beat: tag B waits on |
| disp_op | input | 4 | Second beat: opcode |
| disp_dst | input | 4 | Second beat: destination tag |
| proto_err | output | 1 | Beat-pairing error pulse |
| pipe_ready | input | 3 | Ready of add, multiply, detect/move pipes |
| iss_valid | output | 3 | One-hot issue strobe toward the pipes |
| iss_a | output | 64 | Issued operand A |
| iss_b | output | 64 | Issued operand B |
| iss_op | output | 4 | Issued opcode |
| iss_dst | output | 4 | Issued destination tag |
| add_res_valid | input | 1 | Add pipe result present |
| add_res_cancel | input | 1 | Add result needs an extra normalization cycle |
| add_res_tag | input | 4 | Add result tag |
| add_res_data | input | 64 | Add result value |
| mul_res_valid | input | 1 | Multiply result present |
| mul_res_tag | input | 4 | Multiply result tag |
| mul_res_data | input | 64 | Multiply result value |
| mv_res_valid | input | 1 | Detect/move result present |
| mv_res_tag | input | 4 | Detect/move result tag |
| mv_res_data | input | 64 | Detect/move result value |

## Verification
A wrong operand state shows up on iss_valid in the very cycle it matters: a conversion step that is skipped or doubled moves the issue by exactly one cycle, and a missed tag capture stops the entry from issuing at all. A wrong half-merge or a stale forwarded value shows up on iss_a or iss_b in the same cycle as the issue strobe. Errors in age or occupancy tracking show up as issues in the wrong order, or as disp_ready being wrong when the station has just filled. The bench pins every expected issue to a single cycle, so any of these faults is caught within one cycle of the point where it changes the port behaviour.

// File: rtl/fprs_pkg.sv
package fprs_pkg;

    localparam int HALF_W = 32;
    localparam int FULL_W = 2 * HALF_W;
    localparam int TAG_W  = 4;
    localparam int OP_W   = 4;
    localparam int NPIPE  = 3;
    localparam int NBUS   = 4;

    localparam logic [1:0] SRC_EXT  = 2'b00;
    localparam logic [1:0] SRC_INT  = 2'b01;
    localparam logic [1:0] SRC_WAIT = 2'b10;

    typedef enum logic [1:0] {
        OPS_WAIT = 2'd0,
        OPS_CONV = 2'd1,
        OPS_RDY  = 2'd2
    } opst_e;

    typedef struct packed {
        logic [FULL_W-1:0] data;
        opst_e             st;
        logic              raw;
        logic [TAG_W-1:0]  tag;
    } opnd_t;

    typedef struct packed {
        logic             busy;
        logic             full;
        opnd_t            a;
        opnd_t            b;
        logic [OP_W-1:0]  op;
        logic [TAG_W-1:0] dst;
    } entry_t;

    typedef struct packed {
        logic              v;
        logic [TAG_W-1:0]  tag;
        logic [FULL_W-1:0] data;
    } bus_t;

    function automatic logic [NPIPE-1:0] pipe_sel(logic [OP_W-1:0] op);
        case (op[OP_W-1 -: 2])
            2'b00:   return 3'b001;
            2'b01:   return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic opst_e start_state(logic [1:0] src);
        case (src)
            SRC_INT:  return OPS_RDY;
            SRC_WAIT: return OPS_WAIT;
            default:  return OPS_CONV;
        endcase
    endfunction

    function automatic opnd_t snoop(opnd_t o, bus_t [NBUS-1:0] bus);
        opnd_t r;
        r = o;
        for (int k = 0; k < NBUS; k++) begin
            if (o.st == OPS_WAIT && bus[k].v && bus[k].tag == o.tag) begin
                r.data = bus[k].data;
                r.st   = OPS_RDY;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/fprs_merge.sv
module fprs_merge import fprs_pkg::*; #(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             disp_valid,
    input  logic             disp_fill,
    input  logic [DEPTH-1:0] free_mask,
    output logic             disp_ready,
    output logic             do_fill,
    output logic             do_hi,
    output logic [IDX_W-1:0] slot,
    output logic             proto_err
);

    logic             pend;
    logic [IDX_W-1:0] pend_slot;
    logic [IDX_W-1:0] first_free;
    logic             acc;
    logic             bad;

    always_comb begin
        first_free = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_mask[i]) first_free = IDX_W'(i);
        end
    end

    assign disp_ready = pend | (|free_mask) | ~disp_fill;
    assign acc        = disp_valid & disp_ready;
    assign do_fill    = acc & disp_fill;
    assign do_hi      = acc & ~disp_fill & pend;
    assign slot       = pend ? pend_slot : first_free;
    assign bad        = acc & (disp_fill == pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            pend_slot <= '0;
            proto_err <= 1'b0;
        end else begin
            proto_err <= bad;
            if (do_fill) begin
                pend      <= 1'b1;
                pend_slot <= slot;
            end else if (do_hi) begin
                pend      <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fprs_fwd.sv
module fprs_fwd import fprs_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              add_v,
    input  logic              add_cancel,
    input  logic [TAG_W-1:0]  add_tag,
    input  logic [FULL_W-1:0] add_data,
    input  logic              mul_v,
    input  logic [TAG_W-1:0]  mul_tag,
    input  logic [FULL_W-1:0] mul_data,
    input  logic              mv_v,
    input  logic [TAG_W-1:0]  mv_tag,
    input  logic [FULL_W-1:0] mv_data,
    output bus_t [NBUS-1:0]   bus
);

    bus_t late;

    always_ff @(posedge clk) begin
        if (rst) begin
            late <= '0;
        end else begin
            late.v    <= add_v & add_cancel;
            late.tag  <= add_tag;
            late.data <= add_data;
        end
    end

    assign bus[0] = '{v: add_v & ~add_cancel, tag: add_tag, data: add_data};
    assign bus[1] = late;
    assign bus[2] = '{v: mul_v, tag: mul_tag, data: mul_data};
    assign bus[3] = '{v: mv_v, tag: mv_tag, data: mv_data};

endmodule

// File: rtl/fprs_pick.sv
module fprs_pick #(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic [DEPTH-1:0] rdy,
    output logic             grant_v,
    output logic [IDX_W-1:0] grant_idx
);

    logic [DEPTH-1:0] older [DEPTH];
    logic [DEPTH-1:0] blocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) older[i] <= '0;
        end else if (alloc) begin
            for (int i = 0; i < DEPTH; i++) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (IDX_W'(i) == alloc_idx)      older[i][j] <= 1'b0;
                    else if (IDX_W'(j) == alloc_idx) older[i][j] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (rdy[j] && older[j][i]) blocked[i] = 1'b1;
            end
        end
        grant_v   = 1'b0;
        grant_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (rdy[i] && !blocked[i]) begin
                grant_v   = 1'b1;
                grant_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/fprs_top.sv
module fprs_top import fprs_pkg::*; #(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_valid,
    output logic              disp_ready,
    input  logic              disp_fill,
    input  logic [HALF_W-1:0] disp_a_half,
    input  logic [HALF_W-1:0] disp_b_half,
    input  logic [1:0]        disp_a_src,
    input  logic [1:0]        disp_b_src,
    input  logic [TAG_W-1:0]  disp_a_tag,
    input  logic [TAG_W-1:0]  disp_b_tag,
    input  logic [OP_W-1:0]   disp_op,
    input  logic [TAG_W-1:0]  disp_dst,
    output logic              proto_err,
    input  logic [NPIPE-1:0]  pipe_ready,
    output logic [NPIPE-1:0]  iss_valid,
    output logic [FULL_W-1:0] iss_a,
    output logic [FULL_W-1:0] iss_b,
    output logic [OP_W-1:0]   iss_op,
    output logic [TAG_W-1:0]  iss_dst,
    input  logic              add_res_valid,
    input  logic              add_res_cancel,
    input  logic [TAG_W-1:0]  add_res_tag,
    input  logic [FULL_W-1:0] add_res_data,
    input  logic              mul_res_valid,
    input  logic [TAG_W-1:0]  mul_res_tag,
    input  logic [FULL_W-1:0] mul_res_data,
    input  logic              mv_res_valid,
    input  logic [TAG_W-1:0]  mv_res_tag,
    input  logic [FULL_W-1:0] mv_res_data
);

    localparam int IDX_W = $clog2(DEPTH);

    entry_t           ent  [DEPTH];
    entry_t           nxt  [DEPTH];
    logic [DEPTH-1:0] free_mask;
    logic [DEPTH-1:0] rdy_mask;
    logic             do_fill;
    logic             do_hi;
    logic [IDX_W-1:0] slot;
    logic             grant_v;
    logic [IDX_W-1:0] grant_idx;
    bus_t [NBUS-1:0]  bus;

    fprs_merge #(.DEPTH(DEPTH)) u_merge (
        .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_fill(disp_fill),
        .free_mask(free_mask), .disp_ready(disp_ready), .do_fill(do_fill),
        .do_hi(do_hi), .slot(slot), .proto_err(proto_err)
    );

    fprs_fwd u_fwd (
        .clk(clk), .rst(rst),
        .add_v(add_res_valid), .add_cancel(add_res_cancel),
        .add_tag(add_res_tag), .add_data(add_res_data),
        .mul_v(mul_res_valid), .mul_tag(mul_res_tag), .mul_data(mul_res_data),
        .mv_v(mv_res_valid), .mv_tag(mv_res_tag), .mv_data(mv_res_data),
        .bus(bus)
    );

    fprs_pick #(.DEPTH(DEPTH)) u_pick (
        .clk(clk), .rst(rst), .alloc(do_fill), .alloc_idx(slot),
        .rdy(rdy_mask), .grant_v(grant_v), .grant_idx(grant_idx)
    );

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        assign free_mask[gi] = ~ent[gi].busy;
        assign rdy_mask[gi]  = ent[gi].full
                             && ent[gi].a.st == OPS_RDY
                             && ent[gi].b.st == OPS_RDY
                             && |(pipe_sel(ent[gi].op) & pipe_ready);

        always_comb begin
            nxt[gi] = ent[gi];
            if (ent[gi].busy) begin
                nxt[gi].a = snoop(ent[gi].a, bus);
                nxt[gi].b = snoop(ent[gi].b, bus);
            end
            if (ent[gi].full) begin
                if (nxt[gi].a.st == OPS_CONV) nxt[gi].a.st = OPS_RDY;
                if (nxt[gi].b.st == OPS_CONV) nxt[gi].b.st = OPS_RDY;
            end
            if (do_fill && slot == IDX_W'(gi)) begin
                nxt[gi].busy   = 1'b1;
                nxt[gi].full   = 1'b0;
                nxt[gi].a.data = {{HALF_W{1'b0}}, disp_a_half};
                nxt[gi].a.st   = start_state(disp_a_src);
                nxt[gi].a.raw  = disp_a_src != SRC_WAIT;
                nxt[gi].a.tag  = disp_a_tag;
                nxt[gi].b.data = {{HALF_W{1'b0}}, disp_b_half};
                nxt[gi].b.st   = start_state(disp_b_src);
                nxt[gi].b.raw  = disp_b_src != SRC_WAIT;
                nxt[gi].b.tag  = disp_b_tag;
            end
            if (do_hi && slot == IDX_W'(gi)) begin
                nxt[gi].full = 1'b1;
                nxt[gi].op   = disp_op;
                nxt[gi].dst  = disp_dst;
                if (ent[gi].a.raw) nxt[gi].a.data[FULL_W-1:HALF_W] = disp_a_half;
                if (ent[gi].b.raw) nxt[gi].b.data[FULL_W-1:HALF_W] = disp_b_half;
            end
            if (grant_v && grant_idx == IDX_W'(gi)) begin
                nxt[gi].busy = 1'b0;
                nxt[gi].full = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) ent[gi] <= '0;
            else     ent[gi] <= nxt[gi];
        end
    end

    assign iss_valid = grant_v ? pipe_sel(ent[grant_idx].op) : '0;
    assign iss_a     = ent[grant_idx].a.data;
    assign iss_b     = ent[grant_idx].b.data;
    assign iss_op    = ent[grant_idx].op;
    assign iss_dst   = ent[grant_idx].dst;

endmodule

// File: rtl/fprs_chk.sv
module fprs_chk import fprs_pkg::*; (
    input logic             clk,
    input logic             rst,
    input logic             disp_valid,
    input logic             disp_fill,
    input logic             disp_ready,
    input logic             proto_err,
    input logic [NPIPE-1:0] pipe_ready,
    input logic [NPIPE-1:0] iss_valid,
    input logic [OP_W-1:0]  iss_op
);

    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(iss_valid));

    p_target_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (iss_valid & ~pipe_ready) == '0);

    p_add_op_r2: assert property (@(posedge clk) disable iff (rst)
        iss_valid[0] |-> iss_op[OP_W-1 -: 2] == 2'b00);

    p_mul_op_r2: assert property (@(posedge clk) disable iff (rst)
        iss_valid[1] |-> iss_op[OP_W-1 -: 2] == 2'b01);

    p_opbeat_ready_r8: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !disp_fill) |-> disp_ready);

    p_reset_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (iss_valid == '0 && !proto_err && disp_ready));

endmodule

bind fprs_top fprs_chk u_chk (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_fill(disp_fill),
    .disp_ready(disp_ready), .proto_err(proto_err), .pipe_ready(pipe_ready),
    .iss_valid(iss_valid), .iss_op(iss_op)
);

// File: tb/sim_fprs_top.sv
module sim_fprs_top;
    import fprs_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst;
    logic              disp_valid, disp_ready, disp_fill;
    logic [HALF_W-1:0] disp_a_half, disp_b_half;
    logic [1:0]        disp_a_src, disp_b_src;
    logic [TAG_W-1:0]  disp_a_tag, disp_b_tag, disp_dst;
    logic [OP_W-1:0]   disp_op;
    logic              proto_err;
    logic [NPIPE-1:0]  pipe_ready, iss_valid;
    logic [FULL_W-1:0] iss_a, iss_b;
    logic [OP_W-1:0]   iss_op;
    logic [TAG_W-1:0]  iss_dst;
    logic              add_res_valid, add_res_cancel, mul_res_valid, mv_res_valid;
    logic [TAG_W-1:0]  add_res_tag, mul_res_tag, mv_res_tag;
    logic [FULL_W-1:0] add_res_data, mul_res_data, mv_res_data;

    fprs_top u0 (.*);

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [2:0]  pv;
        logic [63:0] a;
        logic [63:0] b;
        logic [3:0]  op;
        logic [3:0]  dst;
        int          at;
        string       req;
    } exp_t;
    exp_t sbq[$];

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(logic [2:0] pv, logic [63:0] a, logic [63:0] b,
                        logic [3:0] op, logic [3:0] dst, int at, string req);
        exp_t e;
        e.pv = pv; e.a = a; e.b = b; e.op = op; e.dst = dst; e.at = at; e.req = req;
        sbq.push_back(e);
    endtask

    // monitor: compare every issue with the oldest expected item
    always @(negedge clk) begin
        if (!rst && iss_valid != 3'b000) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R9", "unexpected issue pv", longint'(iss_valid), 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                n_chk++;
                if (iss_valid !== e.pv || iss_a !== e.a || iss_b !== e.b ||
                    iss_op !== e.op || iss_dst !== e.dst || cyc != e.at) begin
                    n_bad++;
                    $display("FAIL %s issue: actual pv=%b a=%h b=%h op=%h dst=%h cyc=%0d expected pv=%b a=%h b=%h op=%h dst=%h cyc=%0d",
                             e.req, iss_valid, iss_a, iss_b, iss_op, iss_dst, cyc,
                             e.pv, e.a, e.b, e.op, e.dst, e.at);
                end
            end
        end
    end

    // called at posedge+1; returns the cycle number after the second beat's edge
    task automatic pair(input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] asrc, input logic [1:0] bsrc,
                        input logic [3:0] atag, input logic [3:0] btag,
                        input logic [3:0] op, input logic [3:0] dst, output int e2);
        disp_valid = 1'b1; disp_fill = 1'b1;
        disp_a_half = a[31:0]; disp_b_half = b[31:0];
        disp_a_src = asrc; disp_b_src = bsrc; disp_a_tag = atag; disp_b_tag = btag;
        @(posedge clk); #1;
        disp_fill = 1'b0;
        disp_a_half = a[63:32]; disp_b_half = b[63:32];
        disp_op = op; disp_dst = dst;
        @(posedge clk); #1;
        disp_valid = 1'b0;
        e2 = cyc;
    endtask

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic run_tests();
        int e;
        int p;
        // R10 reset state
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        @(negedge clk);
        check(disp_ready === 1'b1, "R10", "disp_ready", longint'(disp_ready), 1);
        check(iss_valid === 3'b000, "R10", "iss_valid", longint'(iss_valid), 0);
        check(proto_err === 1'b0, "R10", "proto_err", longint'(proto_err), 0);
        @(posedge clk); #1;

        // R1 R2 R3: internal-format operands, add pipe, issue right after second beat
        pair(64'hA1A1_0002_A1A1_0001, 64'hB1B1_0002_B1B1_0001, SRC_INT, SRC_INT, 0, 0, 4'h2, 4'h3, e);
        push(3'b001, 64'hA1A1_0002_A1A1_0001, 64'hB1B1_0002_B1B1_0001, 4'h2, 4'h3, e, "R3");
        step(3);

        // R4 R2: A external -> one extra cycle, multiply pipe
        pair(64'hA2A2_0002_A2A2_0001, 64'hB2B2_0002_B2B2_0001, SRC_EXT, SRC_INT, 0, 0, 4'h5, 4'h6, e);
        push(3'b010, 64'hA2A2_0002_A2A2_0001, 64'hB2B2_0002_B2B2_0001, 4'h5, 4'h6, e + 1, "R4");
        step(3);

        // R4 R2: both external, detect/move pipe (op 10xx)
        pair(64'hA3A3_0002_A3A3_0001, 64'hB3B3_0002_B3B3_0001, SRC_EXT, SRC_EXT, 0, 0, 4'h9, 4'h7, e);
        push(3'b100, 64'hA3A3_0002_A3A3_0001, 64'hB3B3_0002_B3B3_0001, 4'h9, 4'h7, e + 1, "R4");
        step(3);

        // R2: op 11xx also goes to detect/move
        pair(64'hA4A4_0002_A4A4_0001, 64'hB4B4_0002_B4B4_0001, SRC_INT, SRC_INT, 0, 0, 4'hD, 4'h8, e);
        push(3'b100, 64'hA4A4_0002_A4A4_0001, 64'hB4B4_0002_B4B4_0001, 4'hD, 4'h8, e, "R2");
        step(3);

        // R5: A waits on tag 5, delivered by the multiply result port
        pair(64'h0, 64'hB5B5_0002_B5B5_0001, SRC_WAIT, SRC_INT, 4'h5, 0, 4'h6, 4'h9, e);
        step(2);
        mul_res_valid = 1'b1; mul_res_tag = 4'h5; mul_res_data = 64'hC0DE_0000_0000_0005;
        push(3'b010, 64'hC0DE_0000_0000_0005, 64'hB5B5_0002_B5B5_0001, 4'h6, 4'h9, cyc + 1, "R5");
        step(1);
        mul_res_valid = 1'b0;
        step(3);

        // R6: add result without cancel
        pair(64'h0, 64'hB6B6_0002_B6B6_0001, SRC_WAIT, SRC_INT, 4'h7, 0, 4'h1, 4'hA, e);
        step(1);
        add_res_valid = 1'b1; add_res_cancel = 1'b0; add_res_tag = 4'h7; add_res_data = 64'h1234_0000_0000_0007;
        push(3'b001, 64'h1234_0000_0000_0007, 64'hB6B6_0002_B6B6_0001, 4'h1, 4'hA, cyc + 1, "R6");
        step(1);
        add_res_valid = 1'b0;
        step(3);

        // R6: add result with cancel arrives one cycle later
        pair(64'h0, 64'hB7B7_0002_B7B7_0001, SRC_WAIT, SRC_INT, 4'h6, 0, 4'h3, 4'hB, e);
        step(1);
        add_res_valid = 1'b1; add_res_cancel = 1'b1; add_res_tag = 4'h6; add_res_data = 64'h5678_0000_0000_0006;
        push(3'b001, 64'h5678_0000_0000_0006, 64'hB7B7_0002_B7B7_0001, 4'h3, 4'hB, cyc + 2, "R6");
        step(1);
        add_res_valid = 1'b0; add_res_cancel = 1'b0;
        step(4);

        // R7: stray second beat -> error pulse, no entry
        disp_valid = 1'b1; disp_fill = 1'b0; disp_op = 4'h0; disp_dst = 4'hF;
        disp_a_half = 32'hDEAD; disp_b_half = 32'hBEEF;
        step(1);
        disp_valid = 1'b0;
        @(negedge clk);
        check(proto_err === 1'b1, "R7", "proto_err stray", longint'(proto_err), 1);
        @(negedge clk);
        check(proto_err === 1'b0, "R7", "proto_err pulse end", longint'(proto_err), 0);
        @(posedge clk); #1;
        step(3);

        // R7: two fills in a row; the later fill pairs with the second beat
        disp_valid = 1'b1; disp_fill = 1'b1; disp_a_src = SRC_INT; disp_b_src = SRC_INT;
        disp_a_half = 32'h0000_0111; disp_b_half = 32'h0000_0222;
        step(1);
        disp_a_half = 32'h0000_0333; disp_b_half = 32'h0000_0444;
        step(1);
        disp_fill = 1'b0; disp_a_half = 32'h0000_0AAA; disp_b_half = 32'h0000_0BBB;
        disp_op = 4'h4; disp_dst = 4'hC;
        @(negedge clk);
        check(proto_err === 1'b1, "R7", "proto_err double fill", longint'(proto_err), 1);
        @(posedge clk); #1;
        disp_valid = 1'b0;
        push(3'b010, 64'h0000_0AAA_0000_0333, 64'h0000_0BBB_0000_0444, 4'h4, 4'hC, cyc, "R7");
        step(3);

        // R8 R9: fill all entries with pipes stalled
        pipe_ready = 3'b000;
        pair(64'hE0, 64'hF0, SRC_INT, SRC_INT, 0, 0, 4'h0, 4'h0, e);
        pair(64'hE1, 64'hF1, SRC_INT, SRC_INT, 0, 0, 4'h4, 4'h1, e);
        pair(64'hE2, 64'hF2, SRC_INT, SRC_INT, 0, 0, 4'h1, 4'h2, e);
        pair(64'hE3, 64'hF3, SRC_INT, SRC_INT, 0, 0, 4'h8, 4'h3, e);
        disp_valid = 1'b1; disp_fill = 1'b1;
        @(negedge clk);
        check(disp_ready === 1'b0, "R8", "disp_ready full fill", longint'(disp_ready), 0);
        disp_fill = 1'b0;
        #1;
        check(disp_ready === 1'b1, "R8", "disp_ready full opbeat", longint'(disp_ready), 1);
        disp_valid = 1'b0;
        @(posedge clk); #1;
        // add pipe stalled: younger multiply and detect/move entries proceed
        pipe_ready = 3'b110;
        p = cyc;
        push(3'b010, 64'h0000_0000_0000_00E1, 64'h0000_0000_0000_00F1, 4'h4, 4'h1, p, "R9");
        push(3'b100, 64'h0000_0000_0000_00E3, 64'h0000_0000_0000_00F3, 4'h8, 4'h3, p + 1, "R9");
        push(3'b001, 64'h0000_0000_0000_00E0, 64'h0000_0000_0000_00F0, 4'h0, 4'h0, p + 3, "R9");
        push(3'b001, 64'h0000_0000_0000_00E2, 64'h0000_0000_0000_00F2, 4'h1, 4'h2, p + 4, "R9");
        step(3);
        pipe_ready = 3'b111;
        step(5);
        check(sbq.size() == 0, "R9", "expected issues left", longint'(sbq.size()), 0);
    endtask

    initial begin
        bit timeout;
        timeout = 1'b0;
        rst = 1'b1;
        disp_valid = 1'b0; disp_fill = 1'b0;
        disp_a_half = '0; disp_b_half = '0; disp_a_src = '0; disp_b_src = '0;
        disp_a_tag = '0; disp_b_tag = '0; disp_op = '0; disp_dst = '0;
        pipe_ready = 3'b111;
        add_res_valid = 1'b0; add_res_cancel = 1'b0; add_res_tag = '0; add_res_data = '0;
        mul_res_valid = 1'b0; mul_res_tag = '0; mul_res_data = '0;
        mv_res_valid = 1'b0; mv_res_tag = '0; mv_res_data = '0;
        fork
            run_tests();
            begin
                repeat (20000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) check(1'b0, "R10", "watchdog expired", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule